// File: doc/BRIEF.md
# ADC Conversion Sequencer with Compare Gate

This block is the digital front of an analog-to-digital converter. A small register bus reaches four registers: a channel/interrupt register, a mode/status register, the result register and a compare level register. The block drives a 5-bit channel code and one-cycle start and abort pulses to a converter. The converter is treated as abstract here. It returns a one-cycle done strobe with the result on a 10-bit bus.

A conversion can start in two ways. In software mode, a write to the channel register starts it. In hardware mode, a rising edge on a trigger pin starts it. The block keeps a busy flag for as long as a conversion runs. When a result comes back, an optional compare stage checks it against the programmed level. The direction is selectable: the test is either "below the level" or "at or above the level". The result is kept only when the test holds. A kept result sets a completion flag, and that flag can raise an interrupt. Writing the channel register while busy cancels the running conversion. The all-ones channel code switches the converter off.

Top module: `adc_ctrl_cmp`

## Requirements
- R1: After reset, the registers read back as follows: the channel register reads 0x1F (channel 11111, interrupt enable 0, done 0), and the mode register, the result and the level all read 0. irq, conv_start and conv_abort are 0. Addresses are 0 for the channel register, 1 for the mode register, 2 for the result and 3 for the level.
- R2: The channel register holds the channel in bits 4:0 and the interrupt enable in bit 6, and its bit 7 reads the done flag. With mode bit 6 at 0, a write to the channel register starts a conversion on a channel other than 11111. conv_start is high for the single cycle after the write, conv_chan shows the new code, and the busy flag (mode register bit 7) reads 1.
- R3: Channel code 11111 disables the converter. No start is issued for it in either trigger mode.
- R4: With mode bit 6 at 1, a write to the channel register does not start a conversion. A rising edge of hw_trig while idle does start one, one cycle later. A trigger held high does not start another.
- R5: A hw_trig rising edge that arrives while a conversion is busy is ignored, and the busy flag stays 1.
- R6: A conv_done strobe during a busy conversion clears the busy flag. With compare off (mode bit 5 at 0), it also latches conv_result into the result register and sets the done flag.
- R7: With compare on, the result is kept only if it matches. With mode bit 4 at 0, a match means the result is below the level. With mode bit 4 at 1, a match means the result is greater than or equal to the level. A result that does not match leaves the result register and the done flag unchanged, but the busy flag still clears.
- R8: A write to the channel register while busy issues a one-cycle conv_abort and clears busy without setting done. In software mode, the same write restarts on the new channel unless that channel is 11111. A done strobe after an abort with no restart is ignored.
- R9: The done flag is cleared by a write to the channel register or by a read of the result register. If a result is latched in the same cycle, setting wins. irq equals done AND interrupt enable.
- R10: Mode register bits 3:0 read 0, and writes to bit 7 have no effect.
- R11: A conv_done strobe while idle changes neither the result nor the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational from the address) |
| hw_trig | input | 1 | Hardware start trigger, rising edge active |
| conv_chan | output | 5 | Channel code to the converter |
| conv_start | output | 1 | One-cycle start pulse |
| conv_abort | output | 1 | One-cycle abort pulse |
| conv_done | input | 1 | Converter finished strobe |
| conv_result | input | 10 | Converter result |
| irq | output | 1 | Completion interrupt |

## Verification
Directed sequences run each start path in turn:
- a software write;
- a hardware edge;
- a held trigger;
- an edge while busy;
- the disable code in both modes.

These tell apart a level-triggered start from an edge-triggered one, and a start gated by the busy flag from one that is not. Compare results are driven on both sides of the level and exactly at it, in both directions. This separates a strict test from an inclusive one and catches an inverted direction bit. A long run with seeded random mixes of writes, reads, done strobes and trigger toggles follows. It is checked every cycle against a reference model. This exposes priority errors when aborts, completions, result reads and triggers collide in one cycle.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  localparam int unsigned CH_W   = 5;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CHAN   = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RESULT = 2'd2;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 2'd3;

  localparam logic [CH_W-1:0] CH_OFF = 5'b11111;

  // channel register bit positions
  localparam int unsigned CHAN_IE_BIT   = 6;
  localparam int unsigned CHAN_DONE_BIT = 7;
  // mode register bit positions
  localparam int unsigned MODE_GE_BIT   = 4;
  localparam int unsigned MODE_CMP_BIT  = 5;
  localparam int unsigned MODE_HW_BIT   = 6;
  localparam int unsigned MODE_BUSY_BIT = 7;

  typedef struct packed {
    logic hw_mode;
    logic cmp_en;
    logic cmp_ge;
  } mode_t;

endpackage

// File: rtl/adc_regs.sv
module adc_regs
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic [RES_W-1:0]     result,
  output logic [CH_W-1:0]      chan,
  output logic                 irq_en,
  output mode_t                mode,
  output logic [RES_W-1:0]     level,
  output logic                 wr_chan,
  output logic                 rd_result
);

  logic [CH_W-1:0]  chan_q, chan_d;
  logic             ie_q, ie_d;
  mode_t            mode_q, mode_d;
  logic [RES_W-1:0] level_q, level_d;
  logic             wr_mode, wr_level;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_chan   = bus_wr && (bus_addr == A_CHAN);
  assign wr_mode   = bus_wr && (bus_addr == A_MODE);
  assign wr_level  = bus_wr && (bus_addr == A_LEVEL);
  assign rd_result = bus_rd && (bus_addr == A_RESULT);

  always_comb begin
    chan_d  = chan_q;
    ie_d    = ie_q;
    mode_d  = mode_q;
    level_d = level_q;
    if (wr_chan) begin
      chan_d = bus_wdata[CH_W-1:0];
      ie_d   = bus_wdata[CHAN_IE_BIT];
    end
    if (wr_mode) begin
      mode_d.hw_mode = bus_wdata[MODE_HW_BIT];
      mode_d.cmp_en  = bus_wdata[MODE_CMP_BIT];
      mode_d.cmp_ge  = bus_wdata[MODE_GE_BIT];
    end
    if (wr_level) begin
      level_d = bus_wdata[RES_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= CH_OFF;
      ie_q    <= 1'b0;
      mode_q  <= '0;
      level_q <= '0;
    end else begin
      chan_q  <= chan_d;
      ie_q    <= ie_d;
      mode_q  <= mode_d;
      level_q <= level_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CHAN: begin
        bus_rdata[CH_W-1:0]     = chan_q;
        bus_rdata[CHAN_IE_BIT]   = ie_q;
        bus_rdata[CHAN_DONE_BIT] = done;
      end
      A_MODE: begin
        bus_rdata[MODE_BUSY_BIT] = busy;
        bus_rdata[MODE_HW_BIT]   = mode_q.hw_mode;
        bus_rdata[MODE_CMP_BIT]  = mode_q.cmp_en;
        bus_rdata[MODE_GE_BIT]   = mode_q.cmp_ge;
      end
      A_RESULT: bus_rdata[RES_W-1:0] = result;
      default:  bus_rdata[RES_W-1:0] = level_q;
    endcase
  end

  assign chan   = chan_q;
  assign irq_en = ie_q;
  assign mode   = mode_q;
  assign level  = level_q;

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_chan,
  input  logic [CH_W-1:0] new_chan,
  input  logic [CH_W-1:0] cur_chan,
  input  logic            hw_mode,
  input  logic            hw_trig,
  input  logic            conv_done,
  output logic            busy,
  output logic            conv_start,
  output logic            conv_abort,
  output logic            accept
);

  logic busy_q, busy_d;
  logic start_q, start_d;
  logic abort_q, abort_d;
  logic trig_q;
  logic trig_rise;

  assign trig_rise = hw_trig && !trig_q;
  assign accept    = conv_done && busy_q && !wr_chan;

  always_comb begin
    busy_d  = busy_q;
    start_d = 1'b0;
    abort_d = 1'b0;
    if (wr_chan) begin
      abort_d = busy_q;
      busy_d  = 1'b0;
      if (!hw_mode && (new_chan != CH_OFF)) begin
        start_d = 1'b1;
        busy_d  = 1'b1;
      end
    end else if (accept) begin
      busy_d = 1'b0;
    end else if (hw_mode && trig_rise && !busy_q && (cur_chan != CH_OFF)) begin
      start_d = 1'b1;
      busy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      abort_q <= abort_d;
      trig_q  <= hw_trig;
    end
  end

  assign busy       = busy_q;
  assign conv_start = start_q;
  assign conv_abort = abort_q;

  AST_START_LIVE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (cur_chan != CH_OFF)); // R3

  AST_ABORT_WAS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chan |=> (conv_abort == $past(busy_q))); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !busy_q); // R6

  AST_BUSY_IGNORES_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !wr_chan && !conv_done) |=> (busy_q && !conv_start)); // R5

endmodule

// File: rtl/adc_cmp.sv
module adc_cmp #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [RES_W-1:0] conv_result,
  input  logic [RES_W-1:0] level,
  input  logic             cmp_en,
  input  logic             cmp_ge,
  input  logic             clr,
  output logic [RES_W-1:0] result,
  output logic             done
);

  logic [RES_W-1:0] result_q, result_d;
  logic             done_q, done_d;
  logic             at_or_above;
  logic             match;
  logic             keep;

  assign at_or_above = (conv_result >= level);
  assign match       = cmp_ge ? at_or_above : !at_or_above;
  assign keep        = accept && (!cmp_en || match);

  always_comb begin
    result_d = result_q;
    done_d   = done_q;
    if (keep) begin
      result_d = conv_result;
      done_d   = 1'b1;
    end else if (clr) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      done_q   <= done_d;
    end
  end

  assign result = result_q;
  assign done   = done_q;

  AST_MISS_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmp_en && !match) |=> $stable(result_q)); // R7

  AST_PLAIN_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmp_en) |=> (done_q && (result_q == $past(conv_result)))); // R6

endmodule

// File: rtl/adc_ctrl_cmp.sv
module adc_ctrl_cmp
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_trig,
  output logic [4:0]        conv_chan,
  output logic              conv_start,
  output logic              conv_abort,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              irq
);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             busy, done, accept, irq_en, wr_chan, rd_result;
  logic [CH_W-1:0]  chan;
  mode_t            mode;
  logic [RES_W-1:0] level, result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  adc_regs #(.RES_W(RES_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .result(result),
    .chan(chan), .irq_en(irq_en), .mode(mode), .level(level),
    .wr_chan(wr_chan), .rd_result(rd_result)
  );

  adc_seq u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .wr_chan(wr_chan), .new_chan(bus_wdata[CH_W-1:0]), .cur_chan(chan),
    .hw_mode(mode.hw_mode), .hw_trig(hw_trig), .conv_done(conv_done),
    .busy(busy), .conv_start(conv_start), .conv_abort(conv_abort),
    .accept(accept)
  );

  adc_cmp #(.RES_W(RES_W)) u_cmp (
    .clk(clk), .rst_n(rst_int_n),
    .accept(accept), .conv_result(conv_result), .level(level),
    .cmp_en(mode.cmp_en), .cmp_ge(mode.cmp_ge),
    .clr(wr_chan || rd_result),
    .result(result), .done(done)
  );

  assign conv_chan = chan;
  assign irq       = done && irq_en;

  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_chan |=> !done); // R9

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (conv_done && !busy && !wr_chan && !rd_result) |=> ($stable(done) && $stable(result))); // R11

endmodule

// File: tb/adc_ctrl_cmp_bench.sv
module adc_ctrl_cmp_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        hw_trig;
  logic [4:0]  conv_chan;
  logic        conv_start, conv_abort, conv_done, irq;
  logic [9:0]  conv_result;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctrl_cmp u_adc_ctrl_cmp (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_trig(hw_trig), .conv_chan(conv_chan), .conv_start(conv_start),
    .conv_abort(conv_abort), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  logic [4:0] m_chan = 5'h1F;
  logic       m_ie = 0, m_done = 0, m_busy = 0;
  logic       m_hw = 0, m_cmp = 0, m_ge = 0;
  logic [9:0] m_level = 0, m_result = 0;
  logic       m_start = 0, m_abort = 0, m_tprev = 0;
  logic       trig_lvl = 0;
  logic [15:0] last_rdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return {8'h00, m_done, m_ie, 1'b0, m_chan};
      2'd1:    return {8'h00, m_busy, m_hw, m_cmp, m_ge, 4'h0};
      2'd2:    return {6'h00, m_result};
      default: return {6'h00, m_level};
    endcase
  endfunction

  function automatic string read_tag(input logic [1:0] a);
    case (a)
      2'd0:    return "R9 chan/done read";
      2'd1:    return "R10 mode read";
      2'd2:    return "R6 result read";
      default: return "R7 level read";
    endcase
  endfunction

  task automatic model_update(input logic wr, input logic rd, input logic [1:0] a,
                              input logic [15:0] wd, input logic dn,
                              input logic [9:0] res, input logic tg);
    logic wr1, rise, pass, setd;
    wr1  = wr && (a == 2'd0);
    rise = tg && !m_tprev;
    setd = 0;
    m_start = 0;
    m_abort = 0;
    if (wr1) begin
      m_abort = m_busy;
      m_busy  = 0;
      if (!m_hw && wd[4:0] != 5'h1F) begin
        m_start = 1;
        m_busy  = 1;
      end
      m_chan = wd[4:0];
      m_ie   = wd[6];
      m_done = 0;
    end else if (dn && m_busy) begin
      m_busy = 0;
      pass = !m_cmp || (m_ge ? (res >= m_level) : (res < m_level));
      if (pass) begin
        m_result = res;
        m_done   = 1;
        setd     = 1;
      end
    end else if (m_hw && rise && !m_busy && m_chan != 5'h1F) begin
      m_start = 1;
      m_busy  = 1;
    end
    if (!setd && rd && a == 2'd2) m_done = 0;
    if (wr && a == 2'd1) {m_hw, m_cmp, m_ge} = wd[6:4];
    if (wr && a == 2'd3) m_level = wd[9:0];
    m_tprev = tg;
  endtask

  task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                      input logic [15:0] wd, input logic dn, input logic [9:0] res);
    @(negedge clk);
    chk("R2 start pulse", {31'd0, conv_start}, {31'd0, m_start});
    chk("R8 abort pulse", {31'd0, conv_abort}, {31'd0, m_abort});
    chk("R2 channel out", {27'd0, conv_chan}, {27'd0, m_chan});
    chk("R9 irq", {31'd0, irq}, {31'd0, m_done && m_ie});
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    conv_done = dn; conv_result = res; hw_trig = trig_lvl;
    #1;
    last_rdata = bus_rdata;
    if (rd) chk(read_tag(a), {16'd0, bus_rdata}, {16'd0, model_read(a)});
    @(posedge clk);
    model_update(wr, rd, a, wd, dn, res, trig_lvl);
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    step(1, 0, a, d, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_conv(input logic [9:0] res);
    step(0, 0, 0, 0, 1, res);
  endtask

  task automatic set_trig(input logic v);
    trig_lvl = v;
    step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [15:0] exp, input string tag);
    step(0, 1, a, 0, 0, 0);
    chk(tag, {16'd0, last_rdata}, {16'd0, exp});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    hw_trig = 0; conv_done = 0; conv_result = 0;
    void'($urandom(32'h5eed_0421));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    rd_exp(2'd0, 16'h001F, "R1 chan reg");
    rd_exp(2'd1, 16'h0000, "R1 mode reg");
    rd_exp(2'd2, 16'h0000, "R1 result");
    rd_exp(2'd3, 16'h0000, "R1 level");
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 start", {31'd0, conv_start}, 0);

    // R11 done strobe while idle
    finish_conv(10'h155);
    rd_exp(2'd2, 16'h0000, "R11 result kept");
    rd_exp(2'd0, 16'h001F, "R11 done kept");

    // R2 software start
    wr_reg(2'd0, 16'h0045);
    chk("R2 start", {31'd0, conv_start}, 1);
    chk("R2 chan", {27'd0, conv_chan}, 5);
    rd_exp(2'd1, 16'h0080, "R2 busy");
    chk("R2 single pulse", {31'd0, conv_start}, 0);

    // R6 plain completion
    finish_conv(10'h2AA);
    chk("R9 irq set", {31'd0, irq}, 1);
    rd_exp(2'd1, 16'h0000, "R6 busy cleared");
    rd_exp(2'd0, 16'h00C5, "R6 done set");
    rd_exp(2'd2, 16'h02AA, "R6 result");
    rd_exp(2'd0, 16'h0045, "R9 read clears done");
    chk("R9 irq cleared", {31'd0, irq}, 0);

    // R7 compare, below-level direction
    wr_reg(2'd3, 16'h0200);
    wr_reg(2'd1, 16'h0020);
    wr_reg(2'd0, 16'h0003);
    finish_conv(10'h250);
    rd_exp(2'd2, 16'h02AA, "R7 miss keeps result");
    rd_exp(2'd0, 16'h0003, "R7 miss keeps done");
    rd_exp(2'd1, 16'h0020, "R7 miss clears busy");
    wr_reg(2'd0, 16'h0003);
    finish_conv(10'h100);
    rd_exp(2'd0, 16'h0083, "R7 below hit");
    rd_exp(2'd2, 16'h0100, "R7 below result");
    // at-or-above direction, boundary
    wr_reg(2'd1, 16'h0030);
    wr_reg(2'd0, 16'h0003);
    finish_conv(10'h1FF);
    rd_exp(2'd2, 16'h0100, "R7 ge miss");
    wr_reg(2'd0, 16'h0003);
    finish_conv(10'h200);
    rd_exp(2'd2, 16'h0200, "R7 ge equal hit");
    wr_reg(2'd1, 16'h0000);

    // R9 write clears done, R3 disable code in software mode
    wr_reg(2'd0, 16'h0003);
    finish_conv(10'h011);
    wr_reg(2'd0, 16'h001F);
    chk("R3 no start sw", {31'd0, conv_start}, 0);
    rd_exp(2'd0, 16'h001F, "R9 write clears done");

    // R8 abort with restart, abort without restart
    wr_reg(2'd0, 16'h0002);
    wr_reg(2'd0, 16'h0007);
    chk("R8 abort", {31'd0, conv_abort}, 1);
    chk("R8 restart", {31'd0, conv_start}, 1);
    chk("R8 new chan", {27'd0, conv_chan}, 7);
    rd_exp(2'd0, 16'h0007, "R8 done not set");
    wr_reg(2'd0, 16'h001F);
    chk("R8 abort off", {31'd0, conv_abort}, 1);
    chk("R8 no restart", {31'd0, conv_start}, 0);
    rd_exp(2'd1, 16'h0000, "R8 idle");
    finish_conv(10'h3FF);
    rd_exp(2'd2, 16'h0011, "R8 late done ignored");

    // R3 disable code in hardware mode
    wr_reg(2'd1, 16'h0040);
    wr_reg(2'd0, 16'h001F);
    set_trig(1);
    chk("R3 no start hw", {31'd0, conv_start}, 0);
    set_trig(0);

    // R4 hardware edge start, R5 busy ignore
    wr_reg(2'd0, 16'h0004);
    chk("R4 write no start", {31'd0, conv_start}, 0);
    set_trig(1);
    chk("R4 edge start", {31'd0, conv_start}, 1);
    set_trig(0);
    set_trig(1);
    chk("R5 busy edge ignored", {31'd0, conv_start}, 0);
    rd_exp(2'd1, 16'h00C0, "R5 still busy");
    finish_conv(10'h123);
    idle(3);
    chk("R4 level no restart", {31'd0, conv_start}, 0);
    set_trig(0);
    set_trig(1);
    chk("R4 second edge", {31'd0, conv_start}, 1);
    finish_conv(10'h050);

    // R10 reserved and read-only bits
    wr_reg(2'd1, 16'h00FF);
    rd_exp(2'd1, 16'h0070, "R10 reserved zero");
    wr_reg(2'd1, 16'h0000);

    // seeded random mix checked against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic wr, rd, dn;
      logic [1:0] a;
      logic [15:0] wd;
      r  = $urandom % 100;
      wr = (r < 18);
      rd = (r >= 18 && r < 55);
      a  = 2'($urandom % 4);
      wd = 16'($urandom);
      if (a == 2'd0 && ($urandom % 5 == 0)) wd[4:0] = 5'h1F;
      if (a == 2'd3) wd[9:0] = 10'h180 + 10'($urandom % 128);
      dn = ($urandom % 6 == 0);
      if ($urandom % 8 == 0) trig_lvl = ~trig_lvl;
      step(wr, rd, a, wd, dn, 10'h180 + 10'($urandom % 128));
    end

    summary();
    $finish;
  end

endmodule